// File: doc/BRIEF.md
# USB Host Controller Configuration and Error-Interrupt Register File

This block is a small 32-bit memory-mapped register file placed next to a USB host controller. Software programs a handful of static configuration fields through a simple register bus. These are a bus-filter bypass nibble, five port strap bits, a frame-length adjust value, an endian select, a coherency select and a bus-master enable. Each field drives its own output port for as long as it holds its value.

The block also holds a two-source error interrupt unit. Source 0 flags an address-decode error and source 1 flags a host system error. A status bit is set by a one-cycle pulse on its hardware event input. Source 0 is also set by any bus access to an offset that the block does not decode. Status bits are cleared by writing one to them. The mask cannot be written directly: one register clears mask bits (enables sources) and another sets them (disables sources). A single registered level interrupt output is high while any unmasked status bit is set.

The bus gives a combinational read response and an error flag in the same cycle as the access. Writes take effect on the clock edge that ends the access.

Top module: `usbh_cfg_regfile`

## Requirements
- R1: After reset the registers read as follows: frame adjust (0x38) = 0x20, bus-master enable (0x48) = 1, interrupt mask (0x68) = 0x3, and every other register = 0. irq_o is 0.
- R2: The configuration registers keep the written value of their field: bypass (0x30) in bits 3:0, straps (0x34) in bits 4:0, frame adjust (0x38) in bits 5:0, and endian (0x40), coherency (0x44), bus-master enable (0x48) and error-response enable (0x60) each in bit 0. Bits above each field read as 0. Each field appears on its output port.
- R3: Writing to status (0x64) clears each bit written as 1 and leaves each bit written as 0 unchanged. Bit 0 is the decode error and bit 1 is the host error.
- R4: Writes to the mask (0x68) are ignored. Writing to 0x6C clears the mask bits written as 1. Writing to 0x70 sets the mask bits written as 1. Both 0x6C and 0x70 read back as 0.
- R5: irq_o is registered. It updates on the same clock edge as the status or mask change that causes it, and equals the OR over sources of (status AND NOT mask).
- R6: A one-cycle pulse on ev_addr_err_i or ev_host_err_i sets status bit 0 or bit 1. When a set and a write-one-to-clear hit the same bit in the same cycle, the bit ends set.
- R7: An access to an offset that is not decoded, including an offset that is not word aligned, sets status bit 0 and reads as 0. bus_err is 1 during that access only when error-response enable (0x60 bit 0) is 1.
- R8: An access to a decoded offset never raises bus_err and never sets a status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| bus_err | output | 1 | Error response (combinational) |
| ev_addr_err_i | input | 1 | Decode-error event pulse (source 0) |
| ev_host_err_i | input | 1 | Host-system-error event pulse (source 1) |
| filt_bypass_o | output | FILT_W | Bus-filter bypass field |
| port_strap_o | output | STRAP_W | Port strap bits |
| frame_adj_o | output | FADJ_W | Frame-length adjust value |
| endian_o | output | 1 | Endian select |
| coherent_o | output | 1 | Coherency select |
| bus_master_en_o | output | 1 | Bus-master enable |
| irq_o | output | 1 | Level interrupt output |

## Verification
The bench targets the indirect mask path. It tries a direct mask write, which a design that decoded the mask as writable would accept. It also reads 0x6C and 0x70 back, and a design that stored those values would return nonzero data. It clears one status bit while the other is set, which exposes a design that clears the whole register, and it fires an event in the same cycle as its own clear, which a design with clear priority would lose. It makes unmapped and misaligned accesses with the error response both off and on. A design that always flagged the error, or that failed to record the decode error, would show a wrong bus_err or a wrong status readback.

// File: rtl/usbh_cfg_pkg.sv
package usbh_cfg_pkg;

   localparam int DATA_W = 32;
   localparam int IRQ_N  = 2;

   // Byte offsets; software depends on these values.
   localparam logic [7:0] OFS_FILT   = 8'h30;
   localparam logic [7:0] OFS_STRAP  = 8'h34;
   localparam logic [7:0] OFS_FADJ   = 8'h38;
   localparam logic [7:0] OFS_ENDIAN = 8'h40;
   localparam logic [7:0] OFS_COHER  = 8'h44;
   localparam logic [7:0] OFS_BMEN   = 8'h48;
   localparam logic [7:0] OFS_ERRCTL = 8'h60;
   localparam logic [7:0] OFS_ISTAT  = 8'h64;
   localparam logic [7:0] OFS_IMASK  = 8'h68;
   localparam logic [7:0] OFS_IEN    = 8'h6C;
   localparam logic [7:0] OFS_IDIS   = 8'h70;

   typedef enum logic [3:0] {
      RID_FILT,
      RID_STRAP,
      RID_FADJ,
      RID_ENDIAN,
      RID_COHER,
      RID_BMEN,
      RID_ERRCTL,
      RID_ISTAT,
      RID_IMASK,
      RID_IEN,
      RID_IDIS,
      RID_NONE
   } reg_id_e;

   function automatic int max_of3(input int a, input int b, input int c);
      int m;
      m = a;
      if (b > m) m = b;
      if (c > m) m = c;
      return m;
   endfunction

endpackage

// File: rtl/usbh_cfg_decode.sv
module usbh_cfg_decode
   import usbh_cfg_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic [ADDR_W-1:0] addr,
   output reg_id_e           id,
   output logic              hit
);

   initial begin
      assert (ADDR_W >= 8) else $error("usbh_cfg_decode: ADDR_W must be at least 8");
   end

   // Full-width compare: misaligned or out-of-window offsets miss.
   always_comb begin
      id = RID_NONE;
      case (addr)
         ADDR_W'(OFS_FILT):   id = RID_FILT;
         ADDR_W'(OFS_STRAP):  id = RID_STRAP;
         ADDR_W'(OFS_FADJ):   id = RID_FADJ;
         ADDR_W'(OFS_ENDIAN): id = RID_ENDIAN;
         ADDR_W'(OFS_COHER):  id = RID_COHER;
         ADDR_W'(OFS_BMEN):   id = RID_BMEN;
         ADDR_W'(OFS_ERRCTL): id = RID_ERRCTL;
         ADDR_W'(OFS_ISTAT):  id = RID_ISTAT;
         ADDR_W'(OFS_IMASK):  id = RID_IMASK;
         ADDR_W'(OFS_IEN):    id = RID_IEN;
         ADDR_W'(OFS_IDIS):   id = RID_IDIS;
         default:             id = RID_NONE;
      endcase
   end

   assign hit = (id != RID_NONE);

   // R7: an offset with nonzero low bits never decodes
   always_comb begin
      if (addr[1:0] != 2'b00) begin
         a_misaligned_miss_r7: assert (!hit) else $error("misaligned offset decoded");
      end
   end

endmodule

// File: rtl/usbh_cfg_field.sv
module usbh_cfg_field #(
   parameter int           W   = 1,
   parameter logic [W-1:0] RST = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_en,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] q
);

   initial begin
      assert (W >= 1 && W <= 32) else $error("usbh_cfg_field: W out of range");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= RST;
      else if (wr_en) q <= wdata;
   end

   // R2: a field changes only when it is written
   p_hold_unwritten_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(q));

   // R2: a write lands exactly the written value
   p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (q == $past(wdata)));

endmodule

// File: rtl/usbh_irq_unit.sv
module usbh_irq_unit #(
   parameter int              NSRC     = 2,
   parameter logic [NSRC-1:0] MASK_RST = '1,
   parameter bit              IRQ_REG  = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] ev,
   input  logic            clr_we,
   input  logic            en_we,
   input  logic            dis_we,
   input  logic [NSRC-1:0] wdata,
   output logic [NSRC-1:0] status,
   output logic [NSRC-1:0] mask,
   output logic            irq
);

   initial begin
      assert (NSRC >= 1 && NSRC <= 32) else $error("usbh_irq_unit: NSRC out of range");
   end

   logic [NSRC-1:0] st_d;
   logic [NSRC-1:0] mk_d;

   for (genvar i = 0; i < NSRC; i++) begin : g_src
      // set has priority over write-one-to-clear
      always_comb begin
         st_d[i] = status[i];
         if (clr_we && wdata[i]) st_d[i] = 1'b0;
         if (ev[i])              st_d[i] = 1'b1;
      end

      always_comb begin
         mk_d[i] = mask[i];
         if (en_we && wdata[i])  mk_d[i] = 1'b0;
         if (dis_we && wdata[i]) mk_d[i] = 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            status[i] <= 1'b0;
            mask[i]   <= MASK_RST[i];
         end else begin
            status[i] <= st_d[i];
            mask[i]   <= mk_d[i];
         end
      end

      // R6: an event pulse always leaves the bit set
      p_event_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
         ev[i] |=> status[i]);

      // R3: write-one clears when no event competes
      p_w1c_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (clr_we && wdata[i] && !ev[i]) |=> !status[i]);

      // R3: without clear-by-one or event the bit holds
      p_status_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (!ev[i] && !(clr_we && wdata[i])) |=> $stable(status[i]));

      // R4: enabling a source clears its mask bit
      p_enable_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (en_we && !dis_we && wdata[i]) |=> !mask[i]);

      // R4: disabling a source sets its mask bit
      p_disable_sets_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (dis_we && wdata[i]) |=> mask[i]);

      // R4: the mask only moves through enable or disable
      p_mask_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
         !(en_we || dis_we) |=> $stable(mask[i]));
   end

   if (IRQ_REG) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= |(st_d & ~mk_d);
      end
      assign irq = irq_q;

      // R5: the registered level tracks the stored status and mask
      p_irq_tracks_r5: assert property (@(posedge clk) disable iff (!rst_n)
         irq == |(status & ~mask));
   end else begin : g_irq_comb
      assign irq = |(status & ~mask);
   end

endmodule

// File: rtl/usbh_cfg_regfile.sv
module usbh_cfg_regfile
   import usbh_cfg_pkg::*;
#(
   parameter int                ADDR_W   = 8,
   parameter int                FILT_W   = 4,
   parameter int                STRAP_W  = 5,
   parameter int                FADJ_W   = 6,
   parameter logic [FADJ_W-1:0] FADJ_RST = 6'h20,
   parameter bit                BMEN_RST = 1'b1,
   parameter bit                IRQ_REG  = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_sel,
   input  logic               bus_we,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   output logic               bus_err,
   input  logic               ev_addr_err_i,
   input  logic               ev_host_err_i,
   output logic [FILT_W-1:0]  filt_bypass_o,
   output logic [STRAP_W-1:0] port_strap_o,
   output logic [FADJ_W-1:0]  frame_adj_o,
   output logic               endian_o,
   output logic               coherent_o,
   output logic               bus_master_en_o,
   output logic               irq_o
);

   localparam int USED_W = max_of3(FILT_W, STRAP_W, max_of3(FADJ_W, IRQ_N, 1));

   initial begin
      assert (USED_W < DATA_W) else $error("usbh_cfg_regfile: field wider than bus");
   end

   reg_id_e id;
   logic    hit;
   logic    wr;
   logic    miss;
   logic    errctl_q;
   logic [IRQ_N-1:0] status;
   logic [IRQ_N-1:0] mask;
   logic [IRQ_N-1:0] ev_all;

   logic unused_wdata_hi;
   assign unused_wdata_hi = ^bus_wdata[DATA_W-1:USED_W];

   usbh_cfg_decode #(.ADDR_W(ADDR_W)) u_dec (
      .addr (bus_addr),
      .id   (id),
      .hit  (hit)
   );

   assign wr   = bus_sel && bus_we && hit;
   assign miss = bus_sel && !hit;

   usbh_cfg_field #(.W(FILT_W), .RST('0)) u_filt (
      .clk(clk), .rst_n(rst_n), .wr_en(wr && id == RID_FILT),
      .wdata(bus_wdata[FILT_W-1:0]), .q(filt_bypass_o));

   usbh_cfg_field #(.W(STRAP_W), .RST('0)) u_strap (
      .clk(clk), .rst_n(rst_n), .wr_en(wr && id == RID_STRAP),
      .wdata(bus_wdata[STRAP_W-1:0]), .q(port_strap_o));

   usbh_cfg_field #(.W(FADJ_W), .RST(FADJ_RST)) u_fadj (
      .clk(clk), .rst_n(rst_n), .wr_en(wr && id == RID_FADJ),
      .wdata(bus_wdata[FADJ_W-1:0]), .q(frame_adj_o));

   usbh_cfg_field #(.W(1), .RST(1'b0)) u_endian (
      .clk(clk), .rst_n(rst_n), .wr_en(wr && id == RID_ENDIAN),
      .wdata(bus_wdata[0]), .q(endian_o));

   usbh_cfg_field #(.W(1), .RST(1'b0)) u_coher (
      .clk(clk), .rst_n(rst_n), .wr_en(wr && id == RID_COHER),
      .wdata(bus_wdata[0]), .q(coherent_o));

   usbh_cfg_field #(.W(1), .RST(BMEN_RST)) u_bmen (
      .clk(clk), .rst_n(rst_n), .wr_en(wr && id == RID_BMEN),
      .wdata(bus_wdata[0]), .q(bus_master_en_o));

   usbh_cfg_field #(.W(1), .RST(1'b0)) u_errctl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr && id == RID_ERRCTL),
      .wdata(bus_wdata[0]), .q(errctl_q));

   // source 0: decode error (external pulse or local miss), source 1: host error
   assign ev_all = {ev_host_err_i, ev_addr_err_i | miss};

   usbh_irq_unit #(.NSRC(IRQ_N), .MASK_RST('1), .IRQ_REG(IRQ_REG)) u_irq (
      .clk    (clk),
      .rst_n  (rst_n),
      .ev     (ev_all),
      .clr_we (wr && id == RID_ISTAT),
      .en_we  (wr && id == RID_IEN),
      .dis_we (wr && id == RID_IDIS),
      .wdata  (bus_wdata[IRQ_N-1:0]),
      .status (status),
      .mask   (mask),
      .irq    (irq_o)
   );

   always_comb begin
      bus_rdata = '0;
      case (id)
         RID_FILT:   bus_rdata = DATA_W'(filt_bypass_o);
         RID_STRAP:  bus_rdata = DATA_W'(port_strap_o);
         RID_FADJ:   bus_rdata = DATA_W'(frame_adj_o);
         RID_ENDIAN: bus_rdata = DATA_W'(endian_o);
         RID_COHER:  bus_rdata = DATA_W'(coherent_o);
         RID_BMEN:   bus_rdata = DATA_W'(bus_master_en_o);
         RID_ERRCTL: bus_rdata = DATA_W'(errctl_q);
         RID_ISTAT:  bus_rdata = DATA_W'(status);
         RID_IMASK:  bus_rdata = DATA_W'(mask);
         default:    bus_rdata = '0;
      endcase
   end

   assign bus_err = miss && errctl_q;

   // R7: an error response only for a missed access with responses enabled
   p_err_only_miss_r7: assert property (@(posedge clk) disable iff (!rst_n)
      bus_err |-> (bus_sel && !hit && errctl_q));

   // R7: a missed access reads zero
   p_miss_reads_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !hit) |-> (bus_rdata == '0));

   // R7: a missed access records the decode error
   p_miss_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !hit) |=> status[0]);

   // R8: a decoded access never errors
   p_hit_no_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && hit) |-> !bus_err);

   // R4: enable and disable offsets always read zero
   p_trig_read_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && (id == RID_IEN || id == RID_IDIS)) |-> (bus_rdata == '0));

endmodule

// File: tb/tb_usbh_cfg_regfile.sv
`timescale 1ns/1ps
module tb_usbh_cfg_regfile;

   localparam int ADDR_W = 8;
   localparam int NVEC   = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_we = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        bus_err;
   logic        ev_addr_err_i = 1'b0;
   logic        ev_host_err_i = 1'b0;
   logic [3:0]  filt_bypass_o;
   logic [4:0]  port_strap_o;
   logic [5:0]  frame_adj_o;
   logic        endian_o;
   logic        coherent_o;
   logic        bus_master_en_o;
   logic        irq_o;

   int n_chk  = 0;
   int n_fail = 0;
   logic [31:0] rd_val;
   logic        rd_err;

   always #2 clk = ~clk;

   usbh_cfg_regfile #(.ADDR_W(ADDR_W)) dut (
      .clk(clk), .rst_n(rst_n),
      .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
      .ev_addr_err_i(ev_addr_err_i), .ev_host_err_i(ev_host_err_i),
      .filt_bypass_o(filt_bypass_o), .port_strap_o(port_strap_o),
      .frame_adj_o(frame_adj_o), .endian_o(endian_o), .coherent_o(coherent_o),
      .bus_master_en_o(bus_master_en_o), .irq_o(irq_o)
   );

   // {offset, write data, expected readback}
   localparam logic [71:0] VEC [NVEC] = '{
      {8'h30, 32'hFFFF_FFFF, 32'h0000_000F},
      {8'h30, 32'h0000_000A, 32'h0000_000A},
      {8'h34, 32'hFFFF_FFF5, 32'h0000_0015},
      {8'h38, 32'hFFFF_FF3F, 32'h0000_003F},
      {8'h38, 32'h1234_5611, 32'h0000_0011},
      {8'h40, 32'hFFFF_FFFE, 32'h0000_0000},
      {8'h40, 32'h8000_0001, 32'h0000_0001},
      {8'h44, 32'h0000_0003, 32'h0000_0001},
      {8'h48, 32'hFFFF_FFFE, 32'h0000_0000},
      {8'h60, 32'h0000_0000, 32'h0000_0000}
   };

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      #1 rd_err = bus_err;
      @(posedge clk);
      #1 bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   task automatic bus_read(input logic [7:0] a);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
      #1 rd_val = bus_rdata; rd_err = bus_err;
      @(posedge clk);
      #1 bus_sel = 1'b0;
   endtask

   task automatic pulse_host();
      @(negedge clk);
      ev_host_err_i = 1'b1;
      @(posedge clk);
      #1 ev_host_err_i = 1'b0;
   endtask

   initial begin
      #(4 * 150000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: reset values through the bus and at the ports
      bus_read(8'h30); check("R1 bypass", rd_val, 32'h0);
      bus_read(8'h34); check("R1 straps", rd_val, 32'h0);
      bus_read(8'h38); check("R1 frame adjust", rd_val, 32'h20);
      bus_read(8'h40); check("R1 endian", rd_val, 32'h0);
      bus_read(8'h44); check("R1 coherency", rd_val, 32'h0);
      bus_read(8'h48); check("R1 bus master", rd_val, 32'h1);
      bus_read(8'h60); check("R1 err ctl", rd_val, 32'h0);
      bus_read(8'h64); check("R1 status", rd_val, 32'h0);
      bus_read(8'h68); check("R1 mask", rd_val, 32'h3);
      check("R1 irq", {31'b0, irq_o}, 32'h0);
      check("R1 frame port", {26'b0, frame_adj_o}, 32'h20);

      // R2: table of write/readback vectors
      for (int i = 0; i < NVEC; i++) begin
         bus_write(VEC[i][71:64], VEC[i][63:32]);
         bus_read(VEC[i][71:64]);
         check($sformatf("R2 vector %0d", i), rd_val, VEC[i][31:0]);
      end
      check("R2 bypass port", {28'b0, filt_bypass_o}, 32'hA);
      check("R2 strap port", {27'b0, port_strap_o}, 32'h15);
      check("R2 frame port", {26'b0, frame_adj_o}, 32'h11);
      check("R2 endian port", {31'b0, endian_o}, 32'h1);
      check("R2 coherency port", {31'b0, coherent_o}, 32'h1);
      check("R2 bus master port", {31'b0, bus_master_en_o}, 32'h0);

      // R4: direct mask write ignored
      bus_write(8'h68, 32'h0);
      bus_read(8'h68); check("R4 mask write ignored", rd_val, 32'h3);
      check("R4 irq after mask write", {31'b0, irq_o}, 32'h0);

      // R6 + R5: event while masked
      pulse_host();
      check("R5 irq stays low while masked", {31'b0, irq_o}, 32'h0);
      bus_read(8'h64); check("R6 host event sets bit 1", rd_val, 32'h2);

      // R4 + R5: enable source 1
      bus_write(8'h6C, 32'h2);
      check("R5 irq rises with enable", {31'b0, irq_o}, 32'h1);
      bus_read(8'h68); check("R4 enable clears mask bit", rd_val, 32'h1);
      bus_read(8'h6C); check("R4 enable reads zero", rd_val, 32'h0);

      // R3: clearing the other bit leaves bit 1
      bus_write(8'h64, 32'h1);
      bus_read(8'h64); check("R3 write of 0 keeps bit", rd_val, 32'h2);
      check("R5 irq held", {31'b0, irq_o}, 32'h1);
      bus_write(8'h64, 32'h2);
      check("R5 irq falls with clear", {31'b0, irq_o}, 32'h0);
      bus_read(8'h64); check("R3 write of 1 clears", rd_val, 32'h0);

      // R6: set wins over a same-cycle clear
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 8'h64; bus_wdata = 32'h2;
      ev_host_err_i = 1'b1;
      @(posedge clk);
      #1 bus_sel = 1'b0; bus_we = 1'b0; ev_host_err_i = 1'b0;
      bus_read(8'h64); check("R6 set beats clear", rd_val, 32'h2);
      check("R5 irq with set-wins", {31'b0, irq_o}, 32'h1);
      bus_write(8'h64, 32'h3);

      // R7: unmapped read with error response off
      bus_read(8'h50);
      check("R7 unmapped reads zero", rd_val, 32'h0);
      check("R7 no err when disabled", {31'b0, rd_err}, 32'h0);
      bus_read(8'h64); check("R7 decode error recorded", rd_val, 32'h1);
      check("R5 decode error masked", {31'b0, irq_o}, 32'h0);
      bus_write(8'h6C, 32'h1);
      check("R5 irq after enabling source 0", {31'b0, irq_o}, 32'h1);
      bus_write(8'h70, 32'h3);
      check("R5 irq after disable", {31'b0, irq_o}, 32'h0);
      bus_read(8'h68); check("R4 disable sets mask", rd_val, 32'h3);
      bus_read(8'h70); check("R4 disable reads zero", rd_val, 32'h0);
      bus_write(8'h64, 32'h1);

      // R7: error response on
      bus_write(8'h60, 32'h1);
      bus_write(8'h7C, 32'hDEAD_BEEF);
      check("R7 err on unmapped write", {31'b0, rd_err}, 32'h1);
      bus_write(8'h64, 32'h1);
      bus_read(8'h31);
      check("R7 err on misaligned", {31'b0, rd_err}, 32'h1);
      check("R7 misaligned reads zero", rd_val, 32'h0);
      bus_read(8'h64); check("R7 misaligned flags decode", rd_val, 32'h1);
      bus_write(8'h64, 32'h1);

      // R8: decoded accesses raise nothing
      bus_read(8'h38);
      check("R8 no err on mapped read", {31'b0, rd_err}, 32'h0);
      bus_write(8'h44, 32'h0);
      check("R8 no err on mapped write", {31'b0, rd_err}, 32'h0);
      bus_read(8'h64); check("R8 status untouched", rd_val, 32'h0);

      // R6: external decode-error pulse
      @(negedge clk);
      ev_addr_err_i = 1'b1;
      @(posedge clk);
      #1 ev_addr_err_i = 1'b0;
      bus_read(8'h64); check("R6 addr event sets bit 0", rd_val, 32'h1);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule